// File: doc/BRIEF.md
# Shifted-Index Store Address Unit

This block turns one decoded floating-point store into a store request for the memory side. The index operand is scaled down first. It is shifted right, with zero fill, by one more than a two-bit shift field, so by 1 to 4 places. The scaled index is then added to a base. The base is either the first source register or zero, depending on the form. The block also chooses the byte count and the data for the store. For the update forms it issues a write-back of the computed address to the base register.

Forms that cannot be executed do not produce a store request. These are an update form naming register 0 as its base, and an undefined opcode. Such a form raises a one-cycle fault strobe instead. The block does not convert double precision to single precision. The converted single value arrives on its own input and is only selected.

A small state machine holds the result of the previous cycle. It has three states. `S_IDLE` means no request was accepted. `S_STORE` means a valid request is on the outputs. `S_FAULT` means an invalid form was seen. On every clock edge the next state is picked the same way:
- with `in_valid` high and a valid form, go to `S_STORE`;
- with `in_valid` high and an invalid form, go to `S_FAULT`;
- with `in_valid` low, go to `S_IDLE`.

Top module: `sxs_store_agen`

## Requirements
- R1: The address is `base + (rb_val >> (sh+1))`. The shift is logical with zero fill, and the sum wraps modulo 2^64.
- R2: For non-update opcodes, the base is zero when `ra_idx` is 0, and `ra_val` otherwise. The non-update opcodes are 0 (single), 2 (double) and 4 (integer word).
- R3: For update opcodes, the base is always `ra_val`. The update opcodes are 1 (single) and 3 (double). A valid update request also raises `wb_valid`, with `wb_idx` equal to `ra_idx` and `wb_val` equal to the address.
- R4: An update opcode with `ra_idx` equal to 0 raises `bad_form`. It raises neither `st_valid` nor `wb_valid`.
- R5: Opcodes 0 and 1 store 4 bytes. `st_data` is `frs_single` in bits 31:0, with zeros in bits 63:32.
- R6: Opcodes 2 and 3 store 8 bytes, and `st_data` equals `frs_val` unchanged.
- R7: Opcode 4 stores 4 bytes. `st_data` is `frs_val[31:0]` in bits 31:0, with zeros above.
- R8: Results appear exactly one clock after the edge that samples `in_valid` high, and last one cycle. A cycle with `in_valid` low leaves `st_valid`, `wb_valid` and `bad_form` low on the next cycle.
- R9: While reset is active and after it is released, `st_valid`, `wb_valid` and `bad_form` are low.
- R10: Opcodes 5, 6 and 7 raise `bad_form`, with no store and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A store is presented this cycle |
| op | input | 3 | Store opcode (0..4 defined) |
| ra_idx | input | 5 | Base register number |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| sh | input | 2 | Shift field; right shift is sh+1 |
| frs_val | input | 64 | Source floating-point register |
| frs_single | input | 32 | Source already converted to single format |
| st_valid | output | 1 | Store request strobe |
| st_addr | output | 64 | Effective address |
| st_bytes | output | 4 | Store size in bytes (4 or 8) |
| st_data | output | 64 | Store data, right-aligned |
| wb_valid | output | 1 | Base register write-back strobe |
| wb_idx | output | 5 | Register to write back |
| wb_val | output | 64 | Value to write back |
| bad_form | output | 1 | Invalid instruction form strobe |

## Verification
Every result is due one clock after the edge that accepts the request: the address, size, data, write-back and fault strobe. The bench drives inputs at a falling edge. It compares all outputs at the next falling edge, where they are settled and nothing else has changed. It then drops `in_valid`. One cycle later it confirms that every strobe has returned low. The expected values come from a bench function that applies the base rule, the scaled index and the data choice for each opcode. Random operands are mixed with directed cases: wrap-around, every shift amount, register 0 as the base, and the undefined opcodes.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

    typedef enum logic [2:0] {
        SOP_SGL     = 3'd0,
        SOP_SGL_UPD = 3'd1,
        SOP_DBL     = 3'd2,
        SOP_DBL_UPD = 3'd3,
        SOP_INTW    = 3'd4
    } sop_e;

    typedef enum logic [1:0] {
        DS_SINGLE = 2'd0,
        DS_WHOLE  = 2'd1,
        DS_LOWER  = 2'd2
    } dsel_e;

    typedef struct packed {
        logic  upd;
        logic  bad;
        logic  wide;
        dsel_e dsel;
    } sdec_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STORE = 2'd1,
        S_FAULT = 2'd2
    } sstate_e;

endpackage

// File: rtl/sxs_decode.sv
module sxs_decode
    import sxs_pkg::*;
#(
    parameter int RIDX = 5
) (
    input  logic [2:0]      op,
    input  logic [RIDX-1:0] ra_idx,
    output sdec_t           dec
);
    logic ra_zero;
    assign ra_zero = (ra_idx == '0);

    always_comb begin
        dec = '{upd: 1'b0, bad: 1'b0, wide: 1'b0, dsel: DS_SINGLE};
        unique case (op)
            SOP_SGL:     dec.dsel = DS_SINGLE;
            SOP_SGL_UPD: begin
                dec.upd  = 1'b1;
                dec.bad  = ra_zero;
                dec.dsel = DS_SINGLE;
            end
            SOP_DBL: begin
                dec.wide = 1'b1;
                dec.dsel = DS_WHOLE;
            end
            SOP_DBL_UPD: begin
                dec.upd  = 1'b1;
                dec.bad  = ra_zero;
                dec.wide = 1'b1;
                dec.dsel = DS_WHOLE;
            end
            SOP_INTW:    dec.dsel = DS_LOWER;
            default:     dec.bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/sxs_ea.sv
module sxs_ea #(
    parameter int XLEN = 64,
    parameter int SHW  = 2
) (
    input  logic            base_zero,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    input  logic [SHW-1:0]  sh,
    output logic [XLEN-1:0] ea
);
    localparam int SAW = SHW + 1;

    logic [SAW-1:0]  amt;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] base;

    always_comb begin
        amt    = SAW'(sh) + SAW'(1);
        scaled = rb_val >> amt;
        base   = base_zero ? '0 : ra_val;
        ea     = base + scaled;
    end
endmodule

// File: rtl/sxs_data.sv
module sxs_data
    import sxs_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WORD = 32
) (
    input  dsel_e           dsel,
    input  logic [XLEN-1:0] frs_val,
    input  logic [WORD-1:0] frs_single,
    output logic [XLEN-1:0] data
);
    localparam int PAD = XLEN - WORD;

    always_comb begin
        unique case (dsel)
            DS_SINGLE: data = {{PAD{1'b0}}, frs_single};
            DS_WHOLE:  data = frs_val;
            DS_LOWER:  data = {{PAD{1'b0}}, frs_val[WORD-1:0]};
            default:   data = '0;
        endcase
    end
endmodule

// File: rtl/sxs_store_agen.sv
module sxs_store_agen
    import sxs_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WORD = 32,
    parameter int SHW  = 2,
    parameter int RIDX = 5,
    parameter int BW   = $clog2(XLEN / 8) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic [RIDX-1:0] ra_idx,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    input  logic [SHW-1:0]  sh,
    input  logic [XLEN-1:0] frs_val,
    input  logic [WORD-1:0] frs_single,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [BW-1:0]   st_bytes,
    output logic [XLEN-1:0] st_data,
    output logic            wb_valid,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_val,
    output logic            bad_form
);
    localparam int SAW        = SHW + 1;
    localparam int WIDE_BYTES = XLEN / 8;
    localparam int WORD_BYTES = WORD / 8;

    sdec_t           dec;
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] data;

    sxs_decode #(.RIDX(RIDX)) u_decode (
        .op     (op),
        .ra_idx (ra_idx),
        .dec    (dec)
    );

    sxs_ea #(.XLEN(XLEN), .SHW(SHW)) u_ea (
        .base_zero (!dec.upd && (ra_idx == '0)),
        .ra_val    (ra_val),
        .rb_val    (rb_val),
        .sh        (sh),
        .ea        (ea)
    );

    sxs_data #(.XLEN(XLEN), .WORD(WORD)) u_data (
        .dsel       (dec.dsel),
        .frs_val    (frs_val),
        .frs_single (frs_single),
        .data       (data)
    );

    sstate_e         state_q, state_d;
    logic [XLEN-1:0] ea_q, data_q;
    logic [BW-1:0]   bytes_q;
    logic            upd_q;
    logic [RIDX-1:0] idx_q;

    always_comb begin
        if (!in_valid)    state_d = S_IDLE;
        else if (dec.bad) state_d = S_FAULT;
        else              state_d = S_STORE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // payload captured on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= '0;
            data_q  <= '0;
            bytes_q <= '0;
            upd_q   <= 1'b0;
            idx_q   <= '0;
        end else if (in_valid) begin
            ea_q    <= ea;
            data_q  <= data;
            bytes_q <= dec.wide ? BW'(WIDE_BYTES) : BW'(WORD_BYTES);
            upd_q   <= dec.upd;
            idx_q   <= ra_idx;
        end
    end

    // outputs
    always_comb begin
        st_valid = 1'b0;
        wb_valid = 1'b0;
        bad_form = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_STORE: begin
                st_valid = 1'b1;
                wb_valid = upd_q;
            end
            S_FAULT: bad_form = 1'b1;
            default: ;
        endcase
        st_addr  = ea_q;
        st_bytes = bytes_q;
        st_data  = data_q;
        wb_idx   = idx_q;
        wb_val   = ea_q;
    end

    assert_fault_blocks_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> (!st_valid && !wb_valid));

    assert_wb_never_reg0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx != '0));

    assert_wb_with_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> st_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!st_valid && !wb_valid && !bad_form));

    assert_zero_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec.upd && !dec.bad && ra_idx == '0) |=>
            (st_addr == ($past(rb_val) >> (SAW'($past(sh)) + SAW'(1)))));

    assert_undefined_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 3'd4) |=> bad_form);

    assert_narrow_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_bytes == BW'(WORD_BYTES)) |-> (st_data[XLEN-1:WORD] == '0));

    assert_size_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_bytes == BW'(WORD_BYTES) || st_bytes == BW'(WIDE_BYTES)));

endmodule

// File: tb/test_sxs_store_agen.sv
module test_sxs_store_agen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  op;
    logic [4:0]  ra_idx;
    logic [63:0] ra_val, rb_val, frs_val;
    logic [1:0]  sh;
    logic [31:0] frs_single;
    logic        st_valid, wb_valid, bad_form;
    logic [63:0] st_addr, st_data, wb_val;
    logic [3:0]  st_bytes;
    logic [4:0]  wb_idx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sxs_store_agen i_sxs_store_agen (
        .clk, .rst_n, .in_valid, .op, .ra_idx, .ra_val, .rb_val, .sh,
        .frs_val, .frs_single, .st_valid, .st_addr, .st_bytes, .st_data,
        .wb_valid, .wb_idx, .wb_val, .bad_form
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic is_upd(input logic [2:0] o);
        return (o == 3'd1) || (o == 3'd3);
    endfunction

    function automatic logic is_bad(input logic [2:0] o, input logic [4:0] ri);
        return (o > 3'd4) || (is_upd(o) && ri == 5'd0);
    endfunction

    function automatic logic [63:0] exp_addr(input logic [2:0] o, input logic [4:0] ri,
                                             input logic [63:0] ra, input logic [63:0] rb,
                                             input logic [1:0] s);
        logic [63:0] base;
        base = (!is_upd(o) && ri == 5'd0) ? 64'd0 : ra;
        return base + (rb >> (int'(s) + 1));
    endfunction

    function automatic logic [63:0] exp_data(input logic [2:0] o, input logic [63:0] f,
                                             input logic [31:0] fs);
        if (o == 3'd2 || o == 3'd3) return f;
        if (o == 3'd4) return {32'd0, f[31:0]};
        return {32'd0, fs};
    endfunction

    task automatic run_one(input logic [2:0] o, input logic [4:0] ri,
                           input logic [63:0] ra, input logic [63:0] rb,
                           input logic [1:0] s, input logic [63:0] f,
                           input logic [31:0] fs);
        logic bad, upd;
        @(negedge clk);
        // previous cycle had in_valid low
        chk("R8", "idle strobes", {61'd0, st_valid, wb_valid, bad_form}, 64'd0);
        op = o; ra_idx = ri; ra_val = ra; rb_val = rb; sh = s;
        frs_val = f; frs_single = fs; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        bad = is_bad(o, ri);
        upd = is_upd(o);
        if (bad) begin
            chk((o > 3'd4) ? "R10" : "R4", "bad_form", {63'd0, bad_form}, 64'd1);
            chk((o > 3'd4) ? "R10" : "R4", "no store/wb", {62'd0, st_valid, wb_valid}, 64'd0);
        end else begin
            chk("R8", "st_valid", {63'd0, st_valid}, 64'd1);
            chk("R8", "bad_form", {63'd0, bad_form}, 64'd0);
            chk(upd ? "R3" : "R2", "address R1", st_addr, exp_addr(o, ri, ra, rb, s));
            chk((o == 3'd2 || o == 3'd3) ? "R6" : ((o == 3'd4) ? "R7" : "R5"), "bytes",
                {60'd0, st_bytes}, (o == 3'd2 || o == 3'd3) ? 64'd8 : 64'd4);
            chk((o == 3'd2 || o == 3'd3) ? "R6" : ((o == 3'd4) ? "R7" : "R5"), "data",
                st_data, exp_data(o, f, fs));
            chk("R3", "wb_valid", {63'd0, wb_valid}, {63'd0, upd});
            if (upd) begin
                chk("R3", "wb_idx", {59'd0, wb_idx}, {59'd0, ri});
                chk("R3", "wb_val", wb_val, exp_addr(o, ri, ra, rb, s));
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = '0; ra_idx = '0; ra_val = '0;
        rb_val = '0; sh = '0; frs_val = '0; frs_single = '0;
        repeat (3) @(negedge clk);
        chk("R9", "strobes in reset", {61'd0, st_valid, wb_valid, bad_form}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "strobes after reset", {61'd0, st_valid, wb_valid, bad_form}, 64'd0);

        // R1: every shift amount on all-ones index
        for (int s = 0; s < 4; s++)
            run_one(3'd2, 5'd3, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'(s), 64'h1234, 32'h5);
        // R1: wrap-around
        run_one(3'd0, 5'd7, 64'hFFFF_FFFF_FFFF_FFF8, 64'h20, 2'd0, 64'h0, 32'hCAFE_F00D);
        // R2: register 0 base is zero despite a nonzero value
        run_one(3'd4, 5'd0, 64'hDEAD_BEEF_0000_0000, 64'h100, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, 32'h0);
        run_one(3'd2, 5'd0, 64'h55, 64'h40, 2'd1, 64'h0123_4567_89AB_CDEF, 32'h0);
        // R3: update form uses ra_val and writes back
        run_one(3'd3, 5'd9, 64'h1000, 64'h80, 2'd2, 64'hFEDC_BA98_7654_3210, 32'h0);
        run_one(3'd1, 5'd31, 64'h8000_0000_0000_0000, 64'h6, 2'd0, 64'h0, 32'h3F80_0000);
        // R4: update forms with register 0
        run_one(3'd1, 5'd0, 64'h10, 64'h10, 2'd0, 64'h0, 32'h1);
        run_one(3'd3, 5'd0, 64'h10, 64'h10, 2'd0, 64'h0, 32'h1);
        // R7: integer word drops the upper half
        run_one(3'd4, 5'd2, 64'h10, 64'h0, 2'd0, 64'hFFFF_FFFF_1357_9BDF, 32'h2468_ACE0);
        // R10: undefined opcodes
        for (int o = 5; o < 8; o++)
            run_one(3'(o), 5'd4, 64'h0, 64'h0, 2'd0, 64'h0, 32'h0);

        // constrained random mix
        void'($urandom(32'd20240207));
        for (int i = 0; i < 400; i++) begin
            logic [2:0] ro;
            logic [4:0] ri;
            ro = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            ri = ($urandom % 6 == 0) ? 5'd0 : 5'($urandom);
            run_one(ro, ri, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom),
                    {$urandom, $urandom}, $urandom);
        end
        @(negedge clk);
        chk("R8", "final idle", {61'd0, st_valid, wb_valid, bad_form}, 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule